// File: doc/BRIEF.md
# Four-Channel Prescaled Countdown Timer Bank

This block holds four independent down-counting timers behind a small memory-mapped register port. Software gives each channel a reload value and a mode. The channel then counts down from that value, one step per tick of its own prescaler. The prescaler can divide the input clock by 1, 16 or 256. When a count runs out, the channel raises its own interrupt line, and that line stays high until software acknowledges it. The four lines go to an external interrupt controller.

Each channel runs one-shot or periodic. In periodic mode the channel reloads itself on every expiry and keeps counting. Acknowledging a periodic channel through its clear register also restarts the period. A one-shot channel stops at zero. It starts again only when software writes its load or control register.

Top module: `cdtimer_bank`

## Requirements
- R1: There are four identical channels. The address is `{channel[1:0], reg[1:0]}`, where reg 0 is load, 1 is count, 2 is control and 3 is clear. An access to one channel leaves the count, mode and interrupt of every other channel unchanged.
- R2: A write to load stores the data masked to 24 bits. The same write copies that value into the count, restarts the prescaler and drops the channel interrupt.
- R3: Control bit 1 selects divide-by-16 and control bit 2 selects divide-by-256. Bit 1 wins when both are set. With neither bit set, the channel counts on every clock. Counting starts from an enabling control write or a load write. From that write, the interrupt rises exactly L×N clocks later, where L is the load value and N is the divide ratio.
- R4: Control bit 3 enables the channel. While it is clear, the count does not move and no interrupt is raised. A control write with the enable bit set copies the load value into the count and starts counting again.
- R5: Every control write drops the channel interrupt. This discards any expiry that has not been acknowledged.
- R6: Any access to the clear register, read or write, drops the channel interrupt. If control bit 0 (periodic) is set, the same access also copies the load value into the count. In one-shot mode the count is left as it is.
- R7: The count register can be read and can be written directly. Written data is masked to 24 bits, and a write to the count leaves the interrupt unchanged. Reads of load and count return zero above bit 23. Reads of control return only bits 3:0. Reads of clear return zero.
- R8: The channel expires on a tick that arrives while the count is 1. The interrupt is sticky and stays high until it is dropped. On expiry a periodic channel reloads and keeps counting. A one-shot channel goes to 0 and holds there, and it raises no further interrupt until load or control is written.
- R9: After reset, every load, count and control register reads zero and all four interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Channel and register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq_out | output | 4 | Per-channel sticky interrupt lines |

## Verification
Several rules are checked in the RTL on every cycle:
- load and control writes always leave the interrupt low (R2, R5);
- a periodic acknowledge reloads the count (R6);
- an expiry always raises the line (R8), and a one-shot expiry parks the count at zero (R8);
- a disabled, untouched channel keeps its count (R4);
- no divided tick follows straight after a prescaler restart (R3).

Other properties only the bench scenarios can show. These are the exact L×N expiry timing for each divide ratio and the priority of divide-by-16 over divide-by-256. They also cover the stickiness of the interrupt over many cycles, the lack of any restart after a one-shot acknowledge, the register masking, and the independence of the four channels under random programming.

// File: rtl/cdtimer_pkg.sv
package cdtimer_pkg;

  localparam int CTRL_W = 4;
  localparam int B_PER  = 0;
  localparam int B_D16  = 1;
  localparam int B_D256 = 2;
  localparam int B_EN   = 3;

  typedef enum logic [1:0] {
    RG_LOAD  = 2'd0,
    RG_COUNT = 2'd1,
    RG_CTRL  = 2'd2,
    RG_CLEAR = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic wr_load;
    logic wr_count;
    logic wr_ctrl;
    logic clr_acc;
  } strb_t;

endpackage

// File: rtl/cdtimer_regdec.sv
module cdtimer_regdec
  import cdtimer_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 4
) (
  input  logic                          sel_i,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  output strb_t [NCH-1:0]               strb_o
);
  localparam int CH_W = ADDR_W - 2;

  logic [CH_W-1:0] ch_idx;
  reg_sel_e        rg_idx;

  assign ch_idx = addr_i[ADDR_W-1:2];
  assign rg_idx = reg_sel_e'(addr_i[1:0]);

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic hit;
    assign hit                = sel_i && (ch_idx == CH_W'(i));
    assign strb_o[i].wr_load  = hit && wr_i && (rg_idx == RG_LOAD);
    assign strb_o[i].wr_count = hit && wr_i && (rg_idx == RG_COUNT);
    assign strb_o[i].wr_ctrl  = hit && wr_i && (rg_idx == RG_CTRL);
    assign strb_o[i].clr_acc  = hit && (rg_idx == RG_CLEAR);
  end

  logic [NCH*4-1:0] strb_flat;
  assign strb_flat = strb_o;

  always_comb begin
    if (sel_i) begin
      AST_ONE_TARGET: assert ($onehot0(strb_flat)); // R1
    end
  end

endmodule

// File: rtl/cdtimer_prescale.sv
module cdtimer_prescale #(
  parameter int DIVA_LOG = 4,
  parameter int DIVB_LOG = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  input  logic sel_a_i,
  input  logic sel_b_i,
  output logic tick_o
);
  localparam int PSC_W = (DIVB_LOG > DIVA_LOG) ? DIVB_LOG : DIVA_LOG;

  logic [PSC_W-1:0] psc_q;

  // true when the lowest n bits of c are all ones
  function automatic logic low_ones(input logic [PSC_W-1:0] c, input int n);
    logic r;
    r = 1'b1;
    for (int k = 0; k < PSC_W; k++) begin
      if (k < n && !c[k]) r = 1'b0;
    end
    return r;
  endfunction

  logic hit_a, hit_b;
  assign hit_a = low_ones(psc_q, DIVA_LOG);
  assign hit_b = low_ones(psc_q, DIVB_LOG);

  always_comb begin
    if (!run_i)       tick_o = 1'b0;
    else if (sel_a_i) tick_o = hit_a;
    else if (sel_b_i) tick_o = hit_b;
    else              tick_o = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   psc_q <= '0;
    else if (restart_i || !run_i) psc_q <= '0;
    else                          psc_q <= psc_q + 1'b1;
  end

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !(tick_o && (sel_a_i || sel_b_i))); // R3

endmodule

// File: rtl/cdtimer_channel.sv
module cdtimer_channel
  import cdtimer_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int DATA_W   = 32,
  parameter int DIVA_LOG = 4,
  parameter int DIVB_LOG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strb_t             strb_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_load_o,
  output logic [DATA_W-1:0] rd_count_o,
  output logic [DATA_W-1:0] rd_ctrl_o,
  output logic              irq_o
);
  localparam int PAD_C = DATA_W - CNT_W;
  localparam int PAD_K = DATA_W - CTRL_W;

  logic [CNT_W-1:0]  load_q, count_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              irq_q;

  function automatic logic [CNT_W-1:0] fit_cnt(input logic [DATA_W-1:0] d);
    return d[CNT_W-1:0];
  endfunction

  function automatic logic [CTRL_W-1:0] fit_ctrl(input logic [DATA_W-1:0] d);
    return d[CTRL_W-1:0];
  endfunction

  // value after one tick: reload or park on expiry, else step down, zero idles
  function automatic logic [CNT_W-1:0] step_cnt(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] ld,
                                                input logic per);
    if (c == CNT_W'(1))  return per ? ld : '0;
    else if (c == '0)    return '0;
    else                 return c - 1'b1;
  endfunction

  logic [CTRL_W-1:0] ctrl_new;
  logic sw_touch, tick, expire_evt, reload_evt, psc_restart;

  assign ctrl_new    = fit_ctrl(wdata_i);
  assign sw_touch    = strb_i.wr_load | strb_i.wr_count | strb_i.wr_ctrl | strb_i.clr_acc;
  assign reload_evt  = strb_i.wr_load
                     | (strb_i.wr_ctrl && ctrl_new[B_EN])
                     | (strb_i.clr_acc && ctrl_q[B_PER]);
  assign psc_restart = reload_evt | strb_i.wr_ctrl;
  assign expire_evt  = tick && !sw_touch && (count_q == CNT_W'(1));

  cdtimer_prescale #(.DIVA_LOG(DIVA_LOG), .DIVB_LOG(DIVB_LOG)) u_psc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (ctrl_q[B_EN]),
    .restart_i (psc_restart),
    .sel_a_i   (ctrl_q[B_D16]),
    .sel_b_i   (ctrl_q[B_D256]),
    .tick_o    (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q  <= '0;
      count_q <= '0;
      ctrl_q  <= '0;
      irq_q   <= 1'b0;
    end else if (strb_i.wr_load) begin
      load_q  <= fit_cnt(wdata_i);
      count_q <= fit_cnt(wdata_i);
      irq_q   <= 1'b0;
    end else if (strb_i.wr_ctrl) begin
      ctrl_q <= ctrl_new;
      if (ctrl_new[B_EN]) count_q <= load_q;
      irq_q  <= 1'b0;
    end else if (strb_i.clr_acc) begin
      irq_q <= 1'b0;
      if (ctrl_q[B_PER]) count_q <= load_q;
    end else if (strb_i.wr_count) begin
      count_q <= fit_cnt(wdata_i);
    end else if (tick) begin
      count_q <= step_cnt(count_q, load_q, ctrl_q[B_PER]);
      if (expire_evt) irq_q <= 1'b1;
    end
  end

  assign rd_load_o  = {{PAD_C{1'b0}}, load_q};
  assign rd_count_o = {{PAD_C{1'b0}}, count_q};
  assign rd_ctrl_o  = {{PAD_K{1'b0}}, ctrl_q};
  assign irq_o      = irq_q;

  AST_LOAD_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    strb_i.wr_load |=> !irq_o); // R2
  AST_CTRL_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    strb_i.wr_ctrl |=> !irq_o); // R5
  AST_CLEAR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_i.clr_acc && ctrl_q[B_PER]) |=> (count_q == $past(load_q) && !irq_o)); // R6
  AST_EXPIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> irq_o); // R8
  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !ctrl_q[B_PER]) |=> (count_q == '0)); // R8
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_EN] && !sw_touch) |=> $stable(count_q) && (irq_o == $past(irq_o))); // R4

endmodule

// File: rtl/cdtimer_bank.sv
module cdtimer_bank
  import cdtimer_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int CNT_W    = 24,
  parameter int DATA_W   = 32,
  parameter int DIVA_LOG = 4,
  parameter int DIVB_LOG = 8,
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W  = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq_out
);
  strb_t [NCH-1:0]   strb;
  logic [DATA_W-1:0] rd_load  [NCH];
  logic [DATA_W-1:0] rd_count [NCH];
  logic [DATA_W-1:0] rd_ctrl  [NCH];

  cdtimer_regdec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .sel_i  (bus_sel),
    .wr_i   (bus_wr),
    .addr_i (bus_addr),
    .strb_o (strb)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cdtimer_channel #(
      .CNT_W(CNT_W), .DATA_W(DATA_W), .DIVA_LOG(DIVA_LOG), .DIVB_LOG(DIVB_LOG)
    ) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .strb_i     (strb[i]),
      .wdata_i    (bus_wdata),
      .rd_load_o  (rd_load[i]),
      .rd_count_o (rd_count[i]),
      .rd_ctrl_o  (rd_ctrl[i]),
      .irq_o      (irq_out[i])
    );
  end

  logic [CH_W-1:0] rd_ch;
  reg_sel_e        rd_rg;
  assign rd_ch = bus_addr[ADDR_W-1:2];
  assign rd_rg = reg_sel_e'(bus_addr[1:0]);

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_ch == CH_W'(i)) begin
        case (rd_rg)
          RG_LOAD:  bus_rdata = rd_load[i];
          RG_COUNT: bus_rdata = rd_count[i];
          RG_CTRL:  bus_rdata = rd_ctrl[i];
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && rd_rg == RG_CLEAR) |-> (bus_rdata == '0)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> (irq_out == '0)); // R9

endmodule

// File: tb/cdtimer_bank_tb.sv
`timescale 1ns/1ps
module cdtimer_bank_tb;
  localparam int RG_LOAD = 0, RG_COUNT = 1, RG_CTRL = 2, RG_CLEAR = 3;
  localparam logic [31:0] PER = 32'h1, D16 = 32'h2, D256 = 32'h4, EN = 32'h8;
  localparam logic [31:0] MASK = 32'h00FF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  cdtimer_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 180000) begin
      bad = bad + 1;
      $display("FAIL watchdog: act=%0d exp<=180000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  function automatic int ratio(input logic [31:0] ctrl);
    if (ctrl[1])      return 16;
    else if (ctrl[2]) return 256;
    else              return 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int rg, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'(ch * 4 + rg); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int rg, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'(ch * 4 + rg);
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic off_all();
    for (int c = 0; c < 4; c++) wr(c, RG_CTRL, 32'h0);
  endtask

  logic [31:0] v;
  int          dummy;

  initial begin
    dummy = $urandom(32'd2468);
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9 irq", {28'h0, irq_out}, 32'h0);
    for (int c = 0; c < 4; c++) begin
      rd(c, RG_LOAD, v);  chk("R9 load", v, 32'h0);
      rd(c, RG_COUNT, v); chk("R9 count", v, 32'h0);
      rd(c, RG_CTRL, v);  chk("R9 ctrl", v, 32'h0);
    end

    // R2 / R7 masking
    wr(1, RG_LOAD, 32'hABCD_EF12);
    rd(1, RG_LOAD, v);  chk("R2 load mask", v, 32'h00CD_EF12);
    rd(1, RG_COUNT, v); chk("R2 count copy", v, 32'h00CD_EF12);
    wr(1, RG_COUNT, 32'hFF12_3456);
    rd(1, RG_COUNT, v); chk("R7 count mask", v, 32'h0012_3456);
    rd(1, RG_LOAD, v);  chk("R7 load kept", v, 32'h00CD_EF12);
    wr(1, RG_CTRL, 32'hFFFF_FFF0);
    rd(1, RG_CTRL, v);  chk("R7 ctrl mask", v, 32'h0);
    rd(1, RG_CLEAR, v); chk("R7 clear reads 0", v, 32'h0);

    // R4 disabled channel holds
    idle(20);
    rd(1, RG_COUNT, v); chk("R4 hold", v, 32'h0012_3456);
    chk("R4 no irq", {28'h0, irq_out}, 32'h0);

    // R8 / R3 one-shot at full rate, L=5
    wr(0, RG_LOAD, 32'd5);
    wr(0, RG_CTRL, EN);
    idle(4);
    chk("R3 before expiry", {31'h0, irq_out[0]}, 32'h0);
    idle(1);
    chk("R8 expiry", {31'h0, irq_out[0]}, 32'h1);
    rd(0, RG_COUNT, v); chk("R8 oneshot zero", v, 32'h0);
    idle(10);
    chk("R8 sticky", {31'h0, irq_out[0]}, 32'h1);
    rd(0, RG_COUNT, v); chk("R8 oneshot holds", v, 32'h0);
    wr(0, RG_CLEAR, 32'h0);
    chk("R6 clear drops irq", {31'h0, irq_out[0]}, 32'h0);
    rd(0, RG_COUNT, v); chk("R6 oneshot no reload", v, 32'h0);
    idle(20);
    chk("R8 no restart", {31'h0, irq_out[0]}, 32'h0);
    wr(0, RG_CTRL, EN);
    rd(0, RG_COUNT, v); chk("R4 enable reloads", v, 32'd5);
    idle(4);
    chk("R4 rerun early", {31'h0, irq_out[0]}, 32'h0);
    idle(1);
    chk("R4 rerun expiry", {31'h0, irq_out[0]}, 32'h1);

    // R5 control write discards pending expiry
    wr(0, RG_CTRL, 32'h0);
    chk("R5 ctrl drops irq", {31'h0, irq_out[0]}, 32'h0);
    idle(20);
    chk("R5 stays low", {31'h0, irq_out[0]}, 32'h0);

    // R8 / R6 periodic, L=5
    wr(2, RG_LOAD, 32'd5);
    wr(2, RG_CTRL, EN | PER);
    idle(5);
    chk("R8 periodic expiry", {31'h0, irq_out[2]}, 32'h1);
    idle(2);
    rd(2, RG_COUNT, v); chk("R8 periodic continues", v, 32'd3);
    wr(2, RG_CLEAR, 32'h0);
    chk("R6 clear irq", {31'h0, irq_out[2]}, 32'h0);
    rd(2, RG_COUNT, v); chk("R6 periodic reload", v, 32'd5);
    idle(4);
    chk("R6 period early", {31'h0, irq_out[2]}, 32'h0);
    idle(1);
    chk("R6 period expiry", {31'h0, irq_out[2]}, 32'h1);

    // R2 load write drops irq and restarts
    wr(2, RG_LOAD, 32'd7);
    chk("R2 load drops irq", {31'h0, irq_out[2]}, 32'h0);
    rd(2, RG_COUNT, v); chk("R2 load reloads", v, 32'd7);
    idle(6);
    chk("R2 early", {31'h0, irq_out[2]}, 32'h0);
    idle(1);
    chk("R2 expiry", {31'h0, irq_out[2]}, 32'h1);

    // R7 count write leaves irq
    wr(2, RG_COUNT, 32'd300);
    chk("R7 count write keeps irq", {31'h0, irq_out[2]}, 32'h1);
    rd(2, RG_COUNT, v); chk("R7 count written", v, 32'd300);
    wr(2, RG_CTRL, 32'h0);

    // R3 divide ratios on channel 3
    wr(3, RG_LOAD, 32'd3);
    wr(3, RG_CTRL, EN | D16);
    idle(47);
    chk("R3 div16 early", {31'h0, irq_out[3]}, 32'h0);
    idle(1);
    chk("R3 div16 expiry", {31'h0, irq_out[3]}, 32'h1);
    wr(3, RG_LOAD, 32'd2);
    wr(3, RG_CTRL, EN | D256);
    idle(511);
    chk("R3 div256 early", {31'h0, irq_out[3]}, 32'h0);
    idle(1);
    chk("R3 div256 expiry", {31'h0, irq_out[3]}, 32'h1);
    wr(3, RG_CTRL, EN | D16 | D256);
    idle(31);
    chk("R3 priority early", {31'h0, irq_out[3]}, 32'h0);
    idle(1);
    chk("R3 div16 priority", {31'h0, irq_out[3]}, 32'h1);

    // R1 / R3 / R8 random channel runs
    for (int it = 0; it < 30; it++) begin
      int ch, len, n;
      logic [31:0] ctl;
      off_all();
      ch  = int'($urandom % 4);
      len = 1 + int'($urandom % 6);
      ctl = EN | ((32'($urandom % 4)) << 1) | 32'($urandom % 2);
      n   = len * ratio(ctl);
      wr(ch, RG_LOAD, 32'(len));
      wr(ch, RG_CTRL, ctl);
      idle(n - 1);
      chk("R1 random early", {28'h0, irq_out}, 32'h0);
      idle(1);
      chk("R1 random expiry only own channel", {28'h0, irq_out}, 32'h1 << ch);
      rd(ch, RG_COUNT, v);
      chk("R8 random count after expiry", v, ctl[0] ? 32'(len) : 32'h0);
    end

    // R2 / R7 random masking
    off_all();
    for (int it = 0; it < 10; it++) begin
      int ch;
      logic [31:0] d;
      ch = int'($urandom % 4);
      d  = $urandom;
      wr(ch, RG_LOAD, d);
      rd(ch, RG_LOAD, v); chk("R2 random load mask", v, d & MASK);
      d  = $urandom;
      wr(ch, RG_COUNT, d);
      rd(ch, RG_COUNT, v); chk("R7 random count mask", v, d & MASK);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule